// File: doc/BRIEF.md
# Directory Home Controller for Cache Coherence

This block is the home node of a small distributed shared-memory system. For every memory block it owns, it stores a directory entry and the block's data word. Each directory entry holds a coherence state and a presence vector that has one bit per processor. Caches send the home node three kinds of request: read miss, write miss and write-back. The home node answers by sending probes to the caches that hold copies: invalidate, fetch, or fetch-and-invalidate. Each probe is answered by an acknowledge message, and a fetch acknowledge carries the cached data. Once the last acknowledge has arrived, the home node updates the entry and sends a data reply to the requester.

The home node works on one transaction at a time. It accepts no new request until the current one has completed, so probe traffic and directory updates for different blocks never interleave. The network is assumed to deliver messages in the order they were sent. The controller does not have to reorder anything.

A combinational lookup port reads back the state and the presence vector of any block. This port lets a neighbour or a test environment observe the directory.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is Uncached (state code 00) with an all-zero presence vector, block b holds the data value b, and req_ready is high.
- R2: A read miss (kind 0) to an Uncached or Shared block sends no probe. It replies with the memory word, and the block becomes Shared (state code 01) with the requester's bit added to the vector.
- R3: A read miss to an Exclusive block (state code 10) sends a fetch probe (kind 2) to the owner. The acknowledged data is written to memory and returned in the reply. The block becomes Shared, with the bits of both the owner and the requester set.
- R4: A write miss (kind 1) to an Uncached block, or from the current owner of an Exclusive block, sends no probe. It replies with the memory word and leaves the block Exclusive, with only the requester's bit set.
- R5: A write miss to a Shared block sends an invalidate probe (kind 1) to every sharer except the requester. It then replies with the memory word and makes the block Exclusive, with only the requester's bit set. If the requester is the only sharer, no probe is sent.
- R6: A write miss to an Exclusive block owned by another processor sends a fetch-invalidate probe (kind 3) to that owner. The acknowledged data is written to memory and returned in the reply. Ownership moves to the requester.
- R7: A write-back (kind 2) from the owner of an Exclusive block stores the request data in memory, makes the block Uncached and clears its vector. A write-back from any other processor, or to a block that is not Exclusive, changes nothing. No write-back produces a reply.
- R8: req_ready falls in the cycle after a request is accepted. It stays low until the reply has been sent or the write-back has been handled.
- R9: Probes go out one per cycle, in ascending processor index, with one probe per target. The reply is withheld until every probed processor has acknowledged.
- R10: The reply is a single-cycle pulse addressed to the requester, and it carries the requested block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | PW | Requesting processor |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| prb_valid | output | 1 | Probe message valid |
| prb_kind | output | 2 | 1 invalidate, 2 fetch, 3 fetch-invalidate |
| prb_dst | output | PW | Probed processor |
| prb_addr | output | AW | Probed block address |
| ack_valid | input | 1 | Probe acknowledge valid |
| ack_src | input | PW | Acknowledging processor |
| ack_data | input | DW | Data returned by a fetch or fetch-invalidate |
| rep_valid | output | 1 | Data reply valid |
| rep_dst | output | PW | Processor receiving the reply |
| rep_addr | output | AW | Block address of the reply |
| rep_data | output | DW | Block data |
| look_addr | input | AW | Block selected for lookup |
| look_state | output | 2 | State of the selected block |
| look_vec | output | NPROC | Presence vector of the selected block |

## Verification
The bench builds the controller with four processors, four blocks and a 16-bit data word. With only four blocks, a long pseudo-random stream of requests keeps returning to the same entries. This drives every block through every state, and it produces every mix of sharers, including a requester that is already the only sharer or already the owner. Four processors are enough for invalidate fans of up to three probes, so the ascending probe order and the wait for delayed acknowledges are both exercised. The acknowledge delay is varied from request to request.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [PW-1:0]    req_src,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic             prb_valid,
  output logic [1:0]       prb_kind,
  output logic [PW-1:0]    prb_dst,
  output logic [AW-1:0]    prb_addr,
  input  logic             ack_valid,
  input  logic [PW-1:0]    ack_src,
  input  logic [DW-1:0]    ack_data,
  output logic             rep_valid,
  output logic [PW-1:0]    rep_dst,
  output logic [AW-1:0]    rep_addr,
  output logic [DW-1:0]    rep_data,
  input  logic [AW-1:0]    look_addr,
  output logic [1:0]       look_state,
  output logic [NPROC-1:0] look_vec
);

  localparam logic [1:0] UNC = 2'b00, SHR = 2'b01, EXC = 2'b10;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
  localparam logic [1:0] P_NONE = 2'd0, P_INV = 2'd1, P_FET = 2'd2, P_FINV = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_PROBE, S_WAIT, S_REPLY} st_t;
  st_t st;

  logic [1:0]       dstate [NBLK];
  logic [NPROC-1:0] dvec   [NBLK];
  logic [DW-1:0]    mem    [NBLK];

  logic [1:0]       kind_q, pkind;
  logic [PW-1:0]    src_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, fill, rdata_q;
  logic [NPROC-1:0] pend, owe;

  logic [NPROC-1:0] src_bit, cur_vec, ev_mask, pend_next;
  logic [1:0]       cur_st, ev_kind;
  logic [PW-1:0]    pidx;

  assign src_bit = NPROC'(1) << src_q;
  assign cur_st  = dstate[addr_q];
  assign cur_vec = dvec[addr_q];

  always_comb begin
    ev_mask = '0;
    ev_kind = P_NONE;
    if (kind_q == K_RD && cur_st == EXC) begin
      ev_mask = cur_vec;
      ev_kind = P_FET;
    end else if (kind_q == K_WR && cur_st == SHR) begin
      ev_mask = cur_vec & ~src_bit;
      ev_kind = P_INV;
    end else if (kind_q == K_WR && cur_st == EXC && cur_vec != src_bit) begin
      ev_mask = cur_vec;
      ev_kind = P_FINV;
    end
  end

  always_comb begin
    pidx = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (pend[i]) pidx = PW'(i);
  end
  assign pend_next = pend & ~(NPROC'(1) << pidx);

  assign req_ready  = (st == S_IDLE);
  assign prb_valid  = (st == S_PROBE);
  assign prb_kind   = pkind;
  assign prb_dst    = pidx;
  assign prb_addr   = addr_q;
  assign rep_valid  = (st == S_REPLY);
  assign rep_dst    = src_q;
  assign rep_addr   = addr_q;
  assign rep_data   = rdata_q;
  assign look_state = dstate[look_addr];
  assign look_vec   = dvec[look_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_RD;
      src_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      fill    <= '0;
      rdata_q <= '0;
      pend    <= '0;
      owe     <= '0;
      pkind   <= P_NONE;
      for (int b = 0; b < NBLK; b++) begin
        dstate[b] <= UNC;
        dvec[b]   <= '0;
        mem[b]    <= DW'(b);
      end
    end else begin
      if (ack_valid && (st == S_PROBE || st == S_WAIT)) begin
        owe  <= owe & ~(NPROC'(1) << ack_src);
        fill <= ack_data;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q  <= req_kind;
          src_q   <= req_src;
          addr_q  <= req_addr;
          wdata_q <= req_data;
          st      <= S_EVAL;
        end
        S_EVAL: begin
          if (kind_q == K_RD || kind_q == K_WR) begin
            if (ev_mask != '0) begin
              pend  <= ev_mask;
              owe   <= ev_mask;
              pkind <= ev_kind;
              st    <= S_PROBE;
            end else begin
              rdata_q <= mem[addr_q];
              if (kind_q == K_RD) begin
                dstate[addr_q] <= SHR;
                dvec[addr_q]   <= cur_vec | src_bit;
              end else begin
                dstate[addr_q] <= EXC;
                dvec[addr_q]   <= src_bit;
              end
              st <= S_REPLY;
            end
          end else begin
            if (kind_q == K_WB && cur_st == EXC && cur_vec[src_q]) begin
              mem[addr_q]    <= wdata_q;
              dstate[addr_q] <= UNC;
              dvec[addr_q]   <= '0;
            end
            st <= S_IDLE;
          end
        end
        S_PROBE: begin
          pend <= pend_next;
          if (pend_next == '0) st <= S_WAIT;
        end
        S_WAIT: if (owe == '0) begin
          case (pkind)
            P_FET: begin
              mem[addr_q]    <= fill;
              rdata_q        <= fill;
              dstate[addr_q] <= SHR;
              dvec[addr_q]   <= cur_vec | src_bit;
            end
            P_FINV: begin
              mem[addr_q]    <= fill;
              rdata_q        <= fill;
              dstate[addr_q] <= EXC;
              dvec[addr_q]   <= src_bit;
            end
            default: begin
              rdata_q        <= mem[addr_q];
              dstate[addr_q] <= EXC;
              dvec[addr_q]   <= src_bit;
            end
          endcase
          st <= S_REPLY;
        end
        S_REPLY: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_reply_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |=> !rep_valid);

  a_r9_probe_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && $past(prb_valid)) |-> (prb_dst > $past(prb_dst)));

  a_r9_probe_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> (!rep_valid && !req_ready));

  a_r5_no_self_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_kind == P_INV) |-> (prb_dst != rep_dst));

  a_r6_excl_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (look_state == EXC) |-> ($countones(look_vec) == 1));

  a_r7_uncached_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (look_state == UNC) |-> (look_vec == '0));

  a_r2_shared_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (look_state == SHR) |-> (look_vec != '0));

endmodule

// File: tb/dir_home_ctrl_test.sv
`timescale 1ns/1ps
module dir_home_ctrl_test;
  localparam int NP = 4, NB = 4, W = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic req_ready;
  logic [1:0] req_kind = 0; logic [1:0] req_src = 0; logic [1:0] req_addr = 0;
  logic [W-1:0] req_data = 0;
  logic prb_valid; logic [1:0] prb_kind; logic [1:0] prb_dst; logic [1:0] prb_addr;
  logic ack_valid = 0; logic [1:0] ack_src = 0; logic [W-1:0] ack_data = 0;
  logic rep_valid; logic [1:0] rep_dst; logic [1:0] rep_addr; logic [W-1:0] rep_data;
  logic [1:0] look_addr = 0; logic [1:0] look_state; logic [NP-1:0] look_vec;

  dir_home_ctrl #(.NPROC(NP), .NBLK(NB), .DW(W)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, opn = 0;
  logic [1:0]    m_st  [NB];
  logic [NP-1:0] m_vec [NB];
  logic [W-1:0]  m_mem [NB];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] own_data(int o, int a);
    return W'(16'hA000 ^ ((opn & 15) << 4) ^ (o << 8) ^ a);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (op %0d)", tag, what, act, exp, opn);
    end
  endtask

  task automatic look_chk(int a, string tag);
    look_addr = 2'(a);
    #0.5;
    chk(look_state == m_st[a], tag, "state", look_state, m_st[a]);
    chk(look_vec == m_vec[a], tag, "vector", look_vec, m_vec[a]);
  endtask

  task automatic do_op(int k, int s, int a, logic [W-1:0] d, int dly);
    logic [NP-1:0] v, sb, emask, gmask;
    int ekind, owner, last_dst, last_ack, rep_cyc, kind_bad, order_bad, iters;
    bit erep, got_rep, done;
    logic [W-1:0] edata, gdata;
    int gdst, gaddr;
    int qd[8]; int qt[8]; int qh, qtl;
    string tag;
    v = m_vec[a]; sb = NP'(1) << s; emask = 0; ekind = 0; erep = 1; owner = 0;
    for (int i = 0; i < NP; i++) if (v[i]) owner = i;
    edata = m_mem[a];
    if (k == 0) begin
      if (m_st[a] == 2) begin
        tag = "R3"; emask = v; ekind = 2; edata = own_data(owner, a); m_mem[a] = edata;
      end else tag = "R2";
      m_st[a] = 1; m_vec[a] = v | sb;
    end else if (k == 1) begin
      if (m_st[a] == 1) begin tag = "R5"; emask = v & ~sb; ekind = 1; end
      else if (m_st[a] == 2 && v != sb) begin
        tag = "R6"; emask = v; ekind = 3; edata = own_data(owner, a); m_mem[a] = edata;
      end else tag = "R4";
      m_st[a] = 2; m_vec[a] = sb;
    end else begin
      tag = "R7"; erep = 0;
      if (m_st[a] == 2 && v[s]) begin m_mem[a] = d; m_st[a] = 0; m_vec[a] = 0; end
    end

    @(negedge clk);
    chk(req_ready == 1, "R8", "ready before request", req_ready, 1);
    req_kind = 2'(k); req_src = 2'(s); req_addr = 2'(a); req_data = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R8", "ready after accept", req_ready, 0);
    gmask = 0; last_dst = -1; last_ack = -1; rep_cyc = -1; kind_bad = 0; order_bad = 0;
    got_rep = 0; done = 0; iters = 0; qh = 0; qtl = 0; gdata = 0; gdst = 0; gaddr = 0;
    while (!done && iters < 80) begin
      iters++;
      if (prb_valid) begin
        if (prb_kind != 2'(ekind) || prb_addr != 2'(a)) kind_bad++;
        if (int'(prb_dst) <= last_dst) order_bad++;
        last_dst = prb_dst; gmask[prb_dst] = 1;
        qd[qtl % 8] = prb_dst; qt[qtl % 8] = cyc + dly; qtl++;
      end
      if (qh < qtl && cyc >= qt[qh % 8]) begin
        ack_valid = 1; ack_src = 2'(qd[qh % 8]); ack_data = own_data(qd[qh % 8], a);
        last_ack = cyc; qh++;
      end else ack_valid = 0;
      if (rep_valid) begin
        if (got_rep) kind_bad++;
        got_rep = 1; rep_cyc = cyc; gdata = rep_data; gdst = rep_dst; gaddr = rep_addr;
      end else if (got_rep) done = 1;
      if (!erep && req_ready && qh == qtl) done = 1;
      if (erep && !got_rep && req_ready) done = 1;
      if (!done) @(negedge clk);
    end
    ack_valid = 0;
    chk(done, tag, "completion", done, 1);
    chk(gmask == emask, tag, "probe targets", gmask, emask);
    chk(kind_bad == 0, tag, "probe kind/address", kind_bad, 0);
    chk(order_bad == 0, "R9", "probe order", order_bad, 0);
    chk(got_rep == erep, tag, "reply present", got_rep, erep);
    if (erep && got_rep) begin
      chk(gdata == edata, tag, "reply data", gdata, edata);
      chk(gdst == s && gaddr == a, "R10", "reply dst/addr", gdst * 16 + gaddr, s * 16 + a);
      chk(rep_valid == 0, "R10", "reply pulse width", rep_valid, 0);
      if (emask != 0) chk(rep_cyc > last_ack, "R9", "reply after last ack", rep_cyc, last_ack + 1);
    end
    look_chk(a, tag);
    opn++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_vec[b] = 0; m_mem[b] = W'(b); end
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    for (int b = 0; b < NB; b++) look_chk(b, "R1");
    for (int b = 0; b < NB; b++) do_op(0, b, b, 0, 0);
    do_op(0, 1, 0, 0, 0); do_op(0, 2, 0, 0, 0); do_op(0, 3, 0, 0, 0);
    do_op(1, 2, 0, 0, 3);
    do_op(0, 1, 0, 0, 2);
    do_op(1, 3, 0, 0, 1);
    do_op(2, 1, 0, 16'h1234, 0);
    do_op(2, 3, 0, 16'h5678, 0);
    do_op(0, 0, 0, 0, 0);
    do_op(1, 1, 1, 0, 0);
    do_op(1, 1, 1, 0, 0);
    begin
      logic [15:0] r;
      r = 16'hACE1;
      for (int n = 0; n < 700; n++) begin
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        do_op(int'(r[1:0]) % 3, int'(r[3:2]), int'(r[5:4]), r ^ 16'h0F0F, n % 4);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule